// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller with Shortcut Bits

The controller gathers 72 level-sensitive interrupt sources into three banks: a basic bank of 8 sources and two wide banks of 32 sources each. Every source passes through one register stage and is then gated by a per-source enable bit. A single `irq` output is high while any enabled source is active. The output is recomputed every cycle and is never latched, so it falls one cycle after the source that caused it goes away.

Software reaches the controller over a 32-bit register bus with a write strobe and a combinational read port. There are three read-only pending words. Each bank has a write-one-to-set enable register and a write-one-to-clear disable register. The basic bank's pending word is also a top-level status word. It holds two summary bits, one per wide bank, and eleven shortcut bits that copy selected wide-bank sources, so the handler can often find the source with a single read.

A source that has a shortcut is reported only through its shortcut bit and its home-bank pending bit. It never raises its bank's summary bit. Shortcut and summary bits are gated only by the wide banks' own enables: writes to the basic bank's enable or disable registers cannot reach them.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Pending words read at offset 0x00 (basic bank), 0x04 (wide bank 1) and 0x08 (wide bank 2). A wide-bank pending word equals source AND enable, with the sources sampled by one register stage, so a source change shows up in the word one clock edge later.
- R2: Enable registers sit at 0x18 (basic), 0x10 (bank 1) and 0x14 (bank 2), and disable registers at 0x24, 0x1C and 0x20. A 1 written to an enable bit sets that source's enable, a 1 written to a disable bit clears it, and every bit written as 0 keeps its enable unchanged.
- R3: After reset all enables are 0, all three pending words read 0 and `irq` is low, whatever the source inputs are doing.
- R4: Bits 7:0 of the 0x00 word are the basic sources AND their enables. Bits 31:8 of a write to 0x18 or 0x24 are ignored.
- R5: Bit 8 of the 0x00 word is high while any enabled bank 1 source without a shortcut is active, and bit 9 does the same for bank 2. These bits cannot be masked through 0x18 or 0x24.
- R6: Bits 14:10 of the 0x00 word report bank 1 sources 7, 9, 10, 18 and 19, from low bit to high bit. Bits 20:15 report bank 2 sources 21, 22, 23, 24, 25 and 30, from low bit to high bit. A source with a shortcut sets its shortcut bit and its home pending bit, and never sets summary bit 8 or 9.
- R7: A shortcut bit follows only the enable of its source in the home bank. Writes to 0x18 or 0x24 leave it unchanged.
- R8: Bits 31:21 of the 0x00 word read 0. Reads of the enable and disable offsets, and of any offset outside the three pending words, return 0.
- R9: `irq` is the OR of bits 20:0 of the 0x00 word. It is high exactly while some enabled source is active and drops one edge after the last such source goes inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_basic | input | 8 | Basic-bank level sources |
| src_bank1 | input | 32 | Wide bank 1 level sources |
| src_bank2 | input | 32 | Wide bank 2 level sources |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle the assertions check three things: the set, clear and hold rules of each enable register; that `irq` agrees with the three pending words; and that the top word's upper bits and all non-pending offsets read zero. They also check that a bank whose active sources are all shortcut sources leaves its summary bit low. Some behaviour needs chosen stimulus and only the bench scenarios can show it. This covers the exact bit each shortcut source lands on, the one-edge delay from a source to its pending bit, and the fact that writes to the basic bank's enable and disable registers leave summary and shortcut bits untouched.

// File: rtl/irqc_pkg.sv
// Shared constants and helpers for the banked interrupt controller.
// Assumes byte offsets fit in 8 bits and that the bus is 32 bits wide.
package irqc_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int BASIC_N  = 8;
    localparam int WIDE_N   = 32;
    localparam int SC1_N    = 5;
    localparam int SC2_N    = 6;
    localparam int SUM1_BIT = 8;
    localparam int SUM2_BIT = 9;
    localparam int SC1_LSB  = 10;
    localparam int SC2_LSB  = SC1_LSB + SC1_N;
    localparam int TOP_USED = SC2_LSB + SC2_N;

    localparam logic [ADDR_W-1:0] OFF_PEND0 = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_PEND1 = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_PEND2 = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_EN1   = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_EN2   = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_EN0   = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_DIS1  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_DIS2  = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_DIS0  = 8'h24;

    // Home-bank bit index of the k-th shortcut of a wide bank (1 or 2).
    function automatic int sc_home_bit(input int bank, input int k);
        if (bank == 1) begin
            case (k)
                0: return 7;
                1: return 9;
                2: return 10;
                3: return 18;
                default: return 19;
            endcase
        end else begin
            case (k)
                0: return 21;
                1: return 22;
                2: return 23;
                3: return 24;
                4: return 25;
                default: return 30;
            endcase
        end
    endfunction

    // Number of shortcut bits owned by a wide bank.
    function automatic int sc_count(input int bank);
        return (bank == 1) ? SC1_N : SC2_N;
    endfunction

    // Mask of the home-bank bits that own a shortcut.
    function automatic logic [WIDE_N-1:0] sc_mask(input int bank);
        logic [WIDE_N-1:0] m;
        m = '0;
        for (int k = 0; k < sc_count(bank); k++) begin
            m[sc_home_bit(bank, k)] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/irqc_bank.sv
// One bank: samples its level sources once, holds the per-source enables
// (set and clear masks come from the decoder), and presents source AND enable.
// Assumes the decoder never drives set and clear in the same cycle.
module irqc_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic [W-1:0] set_mask,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] pend
);
    logic [W-1:0] src_q;
    logic [W-1:0] en;

    // Register the raw sources so the pending word comes from flops.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src;
    end

    // Enable bits: set by ones in set_mask, cleared by ones in clr_mask.
    always_ff @(posedge clk) begin
        if (!rst_n) en <= '0;
        else        en <= (en | set_mask) & ~clr_mask;
    end

    // Masked pending view.
    assign pend = src_q & en;

    assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0 && clr_mask == '0) |=> ((en & $past(set_mask)) == $past(set_mask)));

    assert_clear_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((en & $past(clr_mask)) == '0));

    assert_zero_bits_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((en & ~$past(set_mask | clr_mask)) == ($past(en) & ~$past(set_mask | clr_mask))));
endmodule

// File: rtl/irqc_shortcut.sv
// Derives the shortcut bits and the summary bit of one wide bank from its
// masked pending word. Purely combinational; BANK selects the shortcut list.
module irqc_shortcut
    import irqc_pkg::*;
#(
    parameter int BANK = 1,
    localparam int N   = sc_count(BANK)
) (
    input  logic [WIDE_N-1:0] pend,
    output logic [N-1:0]      sc,
    output logic              summary
);
    localparam logic [WIDE_N-1:0] MASK = sc_mask(BANK);

    // Route each listed home bit to its shortcut position.
    for (genvar k = 0; k < N; k++) begin : g_sc
        assign sc[k] = pend[sc_home_bit(BANK, k)];
    end

    // Summary covers only sources that have no shortcut.
    assign summary = |(pend & ~MASK);
endmodule

// File: rtl/banked_irq_ctrl.sv
// Top of the three-bank level interrupt controller. Decodes register writes
// into per-bank set/clear masks, assembles the top status word and drives irq.
// Assumes one register access per cycle; reads are combinational.
module banked_irq_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [BASIC_N-1:0] src_basic,
    input  logic [WIDE_N-1:0]  src_bank1,
    input  logic [WIDE_N-1:0]  src_bank2,
    output logic              irq
);
    logic [BASIC_N-1:0] set0, clr0, pend0;
    logic [WIDE_N-1:0]  set1, clr1, pend1;
    logic [WIDE_N-1:0]  set2, clr2, pend2;
    logic [SC1_N-1:0]   sc1;
    logic [SC2_N-1:0]   sc2;
    logic               sum1, sum2;
    logic [DATA_W-1:0]  top_word;

    // Turn a write strobe into per-bank set and clear masks.
    always_comb begin
        set0 = '0; clr0 = '0;
        set1 = '0; clr1 = '0;
        set2 = '0; clr2 = '0;
        if (bus_we) begin
            case (bus_addr)
                OFF_EN0:  set0 = bus_wdata[BASIC_N-1:0];
                OFF_DIS0: clr0 = bus_wdata[BASIC_N-1:0];
                OFF_EN1:  set1 = bus_wdata;
                OFF_DIS1: clr1 = bus_wdata;
                OFF_EN2:  set2 = bus_wdata;
                OFF_DIS2: clr2 = bus_wdata;
                default: ;
            endcase
        end
    end

    irqc_bank #(.W(BASIC_N)) u_bank0 (
        .clk(clk), .rst_n(rst_n), .src(src_basic),
        .set_mask(set0), .clr_mask(clr0), .pend(pend0)
    );
    irqc_bank #(.W(WIDE_N)) u_bank1 (
        .clk(clk), .rst_n(rst_n), .src(src_bank1),
        .set_mask(set1), .clr_mask(clr1), .pend(pend1)
    );
    irqc_bank #(.W(WIDE_N)) u_bank2 (
        .clk(clk), .rst_n(rst_n), .src(src_bank2),
        .set_mask(set2), .clr_mask(clr2), .pend(pend2)
    );

    irqc_shortcut #(.BANK(1)) u_sc1 (.pend(pend1), .sc(sc1), .summary(sum1));
    irqc_shortcut #(.BANK(2)) u_sc2 (.pend(pend2), .sc(sc2), .summary(sum2));

    // Assemble the top status word: basic bits, summaries, shortcuts.
    always_comb begin
        top_word = '0;
        top_word[BASIC_N-1:0]           = pend0;
        top_word[SUM1_BIT]              = sum1;
        top_word[SUM2_BIT]              = sum2;
        top_word[SC1_LSB +: SC1_N]      = sc1;
        top_word[SC2_LSB +: SC2_N]      = sc2;
    end

    // Level request: any reported bit of the top word.
    assign irq = |top_word[TOP_USED-1:0];

    // Read mux: only the three pending words are readable.
    always_comb begin
        case (bus_addr)
            OFF_PEND0: bus_rdata = top_word;
            OFF_PEND1: bus_rdata = pend1;
            OFF_PEND2: bus_rdata = pend2;
            default:   bus_rdata = '0;
        endcase
    end

    assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((pend0 != '0) || (pend1 != '0) || (pend2 != '0)));

    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_PEND0) |-> (bus_rdata[DATA_W-1:TOP_USED] == '0));

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != OFF_PEND0 && bus_addr != OFF_PEND1 && bus_addr != OFF_PEND2)
            |-> (bus_rdata == '0));

    assert_sc_no_summary1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend1 & ~sc_mask(1)) == '0) |-> !top_word[SUM1_BIT]);

    assert_sc_no_summary2_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend2 & ~sc_mask(2)) == '0) |-> !top_word[SUM2_BIT]);
endmodule

// File: tb/banked_irq_ctrl_test.sv
// Directed bench for banked_irq_ctrl: one task per scenario.
module banked_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  src_basic = '0;
    logic [31:0] src_bank1 = '0;
    logic [31:0] src_bank2 = '0;
    logic        irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    banked_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_basic(src_basic),
        .src_bank1(src_bank1), .src_bank2(src_bank2), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic drive(input logic [7:0] b0, input logic [31:0] b1, input logic [31:0] b2);
        @(negedge clk);
        src_basic = b0; src_bank1 = b1; src_bank2 = b2;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h00, d); chk("R3 top word after reset", d, 32'h0);
        rd(8'h04, d); chk("R3 bank1 after reset", d, 32'h0);
        rd(8'h08, d); chk("R3 bank2 after reset", d, 32'h0);
        chk("R3 irq after reset", {31'b0, irq}, 32'h0);
        drive(8'h00, 32'h0, 32'h0);
    endtask

    task automatic t_wide_mask;
        logic [31:0] d;
        drive(8'h00, 32'h3, 32'h0);
        rd(8'h04, d); chk("R1 disabled source hidden", d, 32'h0);
        wr(8'h10, 32'h1);
        rd(8'h04, d); chk("R1 bank1 pending", d, 32'h1);
        rd(8'h00, d); chk("R5 bank1 summary", d, 32'h100);
        chk("R9 irq from summary", {31'b0, irq}, 32'h1);
        wr(8'h1C, 32'h0);
        rd(8'h04, d); chk("R2 zero disable write ignored", d, 32'h1);
        wr(8'h10, 32'h2);
        rd(8'h04, d); chk("R2 set keeps other enables", d, 32'h3);
        wr(8'h1C, 32'h1);
        rd(8'h04, d); chk("R2 clear one bit", d, 32'h2);
        wr(8'h1C, 32'h2);
        rd(8'h00, d); chk("R5 summary drops", d, 32'h0);
        chk("R9 irq drops", {31'b0, irq}, 32'h0);
        drive(8'h00, 32'h0, 32'h1);
        wr(8'h14, 32'h1);
        rd(8'h08, d); chk("R1 bank2 pending", d, 32'h1);
        rd(8'h00, d); chk("R5 bank2 summary", d, 32'h200);
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R5 summary not maskable in basic bank", d, 32'h200);
        wr(8'h20, 32'hFFFF_FFFF);
        drive(8'h00, 32'h0, 32'h0);
    endtask

    task automatic t_shortcut;
        logic [31:0] d;
        drive(8'h00, (32'h1 << 7) | (32'h1 << 19), 32'h0);
        wr(8'h10, 32'h1 << 7);
        rd(8'h04, d); chk("R6 home bit set", d, 32'h0000_0080);
        rd(8'h00, d); chk("R6 bank1 src7 to bit10, no summary", d, 32'h0000_0400);
        wr(8'h10, 32'h1 << 19);
        rd(8'h00, d); chk("R6 bank1 src19 to bit14", d, 32'h0000_4400);
        drive(8'h00, (32'h1 << 7) | (32'h1 << 19) | (32'h1 << 9), (32'h1 << 30) | (32'h1 << 21));
        wr(8'h10, 32'h1 << 9);
        rd(8'h00, d); chk("R6 bank1 src9 to bit11", d, 32'h0000_4C00);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h08, d); chk("R6 bank2 home bits", d, 32'h4020_0000);
        rd(8'h00, d); chk("R6 bank2 src21/30 to bits15/20", d, 32'h0010_CC00);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        drive(8'h00, 32'h0, 32'h0);
    endtask

    task automatic t_sc_mask;
        logic [31:0] d;
        drive(8'h00, 32'h1 << 10, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R7 basic enable cannot unmask shortcut", d, 32'h0);
        chk("R7 irq stays low", {31'b0, irq}, 32'h0);
        wr(8'h10, 32'h1 << 10);
        rd(8'h00, d); chk("R7 home enable unmasks bit12", d, 32'h0000_1000);
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R7 basic disable cannot mask shortcut", d, 32'h0000_1000);
        wr(8'h1C, 32'h1 << 10);
        rd(8'h00, d); chk("R7 home disable masks shortcut", d, 32'h0);
        drive(8'h00, 32'h0, 32'h0);
    endtask

    task automatic t_basic;
        logic [31:0] d;
        drive(8'hA5, 32'h0, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R4 basic pending", d, 32'h0000_00A5);
        wr(8'h24, 32'h0F);
        rd(8'h00, d); chk("R4 basic disable", d, 32'h0000_00A0);
        drive(8'h0F, 32'h0, 32'h0);
        rd(8'h00, d); chk("R4 masked sources only", d, 32'h0);
        chk("R9 irq low with masked sources", {31'b0, irq}, 32'h0);
        wr(8'h24, 32'hF0);
    endtask

    task automatic t_map;
        logic [31:0] d;
        drive(8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFF); wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R8 top word upper bits zero", d, 32'h001F_FFFF);
        rd(8'h04, d); chk("R1 bank1 all", d, 32'hFFFF_FFFF);
        rd(8'h0C, d); chk("R8 offset 0x0C reads 0", d, 32'h0);
        rd(8'h10, d); chk("R8 enable offset reads 0", d, 32'h0);
        rd(8'h24, d); chk("R8 disable offset reads 0", d, 32'h0);
        rd(8'h40, d); chk("R8 unmapped reads 0", d, 32'h0);
    endtask

    task automatic t_level;
        drive(8'h00, 32'h1, 32'h0);
        chk("R9 irq with one source", {31'b0, irq}, 32'h1);
        drive(8'h00, 32'h0, 32'h0);
        chk("R9 irq drops after source", {31'b0, irq}, 32'h0);
        @(negedge clk);
        src_basic = 8'h01;
        #1;
        chk("R1 one register stage before irq", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R1 irq after one edge", {31'b0, irq}, 32'h1);
        src_basic = 8'h00;
        @(negedge clk);
        chk("R9 irq not latched", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        src_basic = 8'hFF; src_bank1 = '1; src_bank2 = '1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wide_mask();
        t_shortcut();
        t_sc_mask();
        t_basic();
        t_map();
        t_level();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule